// File: doc/BRIEF.md
# Dependency-Aware Five-Slot Issue Packer

The packer holds a small in-order window of register-to-register instructions that all come from one thread. Each instruction carries an operation code, one destination register and two source registers. In every cycle the block looks at all pending entries and picks up to five that are free of hazards against older pending entries. It sends them out together as one bundle. A young independent instruction may go ahead of older ones that are still waiting on a result, so the bundle width is filled from whatever parallelism the stream offers.

Instructions enter one per cycle through a valid/ready handshake and are appended behind the youngest pending entry. The bundle is formed combinationally from the registered window. The entries it takes leave the window at the next rising edge, and the survivors slide down so that they stay in program order. A downstream accept input lets the consumer hold off issue. The bench uses this to preload a whole group before packing begins. Every cycle the block reports how many of the five slots went unused.

Top module: `bundle_packer`

## Requirements
- R1: A synchronous active-high reset empties the window. After reset no bundle is emitted and inReady is 1.
- R2: An instruction is written into the window on a rising edge where inValid and inReady are both 1. inReady is 0 exactly when eight entries are pending at the start of the cycle.
- R3: An entry that reads a register written by an older pending entry is not issued in the same bundle. It may issue in the bundle right after the one that carried that writer.
- R4: An entry whose destination is read or written by an older pending entry is not issued until that older entry has left the window.
- R5: An entry with no hazard against any older pending entry is eligible in any bundle, even if older entries are blocked.
- R6: A bundle holds at most five entries. When more are eligible, the oldest go first. Slots fill from slot 0 upward in program order. slotIdx gives the window position, and position 0 is always the oldest pending entry.
- R7: While bundleValid is 1, emptySlots equals five minus the number of valid slots. Otherwise emptySlots is 0.
- R8: bundleValid is 1 exactly when the window is not empty and bundleReady is 1. When bundleValid is 0, nothing leaves the window.
- R9: A window that holds the seven adds of a balanced eight-input sum tree, followed by one unrelated instruction, drains in three bundles. The first has the four leaf adds and the unrelated one (positions 0,1,2,3,7). The second has the two middle adds (positions 0,1). The third has the root add alone (position 0).
- R10: Issued entries are removed at the rising edge. The remaining entries move down to the lowest positions and keep their program order, and a new entry lands directly behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Offered instruction is valid |
| inReady | output | 1 | Window can take an instruction this cycle |
| inOp | input | 4 | Operation code of offered instruction |
| inDst | input | 4 | Destination register number |
| inSrcA | input | 4 | First source register number |
| inSrcB | input | 4 | Second source register number |
| bundleReady | input | 1 | Consumer accepts a bundle this cycle |
| bundleValid | output | 1 | A bundle is issued this cycle |
| slotValid | output | 5 | Per-slot occupied flag, bit s for slot s |
| slotIdx | output | 15 | Window position per slot, 3 bits each, slot s at bits 3s+2:3s |
| slotOp | output | 20 | Operation code per slot, 4 bits each, slot s at bits 4s+3:4s |
| emptySlots | output | 3 | Unused slots in this bundle (0 to 5) |

## Verification
All bundle outputs (bundleValid, slotValid, slotIdx, slotOp, emptySlots) and inReady are combinational from the registered window. They are therefore due in the same cycle as the window state that produces them. An accepted instruction, or the removal of an issued entry, first shows up in the cycle after the rising edge. The bench drives inputs on the falling edge, samples outputs one nanosecond later, and advances its own window model only at the rising edge. This means every comparison uses the model state for exactly the cycle being observed. A dependent entry is expected one bundle after its producer, and the directed drains check that cadence position by position.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  parameter int OP_W  = 4;
  parameter int REG_W = 4;
  parameter int DEPTH = 8;
  parameter int SLOTS = 5;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int POS_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(SLOTS + 1);

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
  } instr_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic [DEPTH-1:0] retire;
    logic             push;
  } strobe_t;
endpackage

// File: rtl/bp_window.sv
module bp_window
  import bpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  instr_t           inInstr,
  output instr_t           ent [DEPTH],
  output logic [DEPTH-1:0] entValid
);
  instr_t           nextEnt [DEPTH];
  logic [DEPTH-1:0] nextValid;

  // compact survivors toward position 0, then append the new entry
  always_comb begin
    logic [POS_W-1:0] k;
    k = '0;
    nextValid = '0;
    for (int i = 0; i < DEPTH; i++) nextEnt[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && !stb.retire[i]) begin
        nextEnt[k[IDX_W-1:0]]   = ent[i];
        nextValid[k[IDX_W-1:0]] = 1'b1;
        k = k + 1'b1;
      end
    end
    if (stb.push && (k < POS_W'(DEPTH))) begin
      nextEnt[k[IDX_W-1:0]]   = inInstr;
      nextValid[k[IDX_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      entValid <= nextValid;
      for (int i = 0; i < DEPTH; i++) ent[i] <= nextEnt[i];
    end
  end
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bpk_pkg::*;
(
  input  instr_t           ent [DEPTH],
  input  logic [DEPTH-1:0] entValid,
  input  logic             inValid,
  input  logic             bundleReady,
  output strobe_t          stb,
  output logic             inReady,
  output logic             bundleValid,
  output logic [SLOTS-1:0] slotValid,
  output logic [IDX_W-1:0] slotIdx [SLOTS],
  output logic [OP_W-1:0]  slotOp [SLOTS],
  output logic [CNT_W-1:0] emptySlots
);
  logic [DEPTH*DEPTH-1:0] conflictFlat;
  logic [DEPTH-1:0]       eligible;
  logic [CNT_W-1:0]       usedCnt;

  // pairwise hazard of entry gi against older entry gj
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
      if (gj < gi) begin : g_older
        assign conflictFlat[gi*DEPTH+gj] = entValid[gj] && (
            (ent[gj].dst == ent[gi].srcA) || (ent[gj].dst == ent[gi].srcB) ||
            (ent[gi].dst == ent[gj].dst)  ||
            (ent[gi].dst == ent[gj].srcA) || (ent[gi].dst == ent[gj].srcB));
      end else begin : g_none
        assign conflictFlat[gi*DEPTH+gj] = 1'b0;
      end
    end
    assign eligible[gi] = entValid[gi] && !(|conflictFlat[gi*DEPTH +: DEPTH]);
  end

  assign inReady     = !entValid[DEPTH-1];
  assign stb.push    = inValid && inReady;
  assign bundleValid = entValid[0] && bundleReady;

  // oldest-first slot assignment
  always_comb begin
    logic [CNT_W-1:0] r;
    r          = '0;
    slotValid  = '0;
    stb.retire = '0;
    for (int s = 0; s < SLOTS; s++) slotIdx[s] = '0;
    if (bundleValid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eligible[i] && (r < CNT_W'(SLOTS))) begin
          stb.retire[i] = 1'b1;
          slotValid[r]  = 1'b1;
          slotIdx[r]    = IDX_W'(i);
          r = r + 1'b1;
        end
      end
    end
    usedCnt = r;
  end

  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_op
    assign slotOp[gs] = slotValid[gs] ? ent[slotIdx[gs]].op : '0;
  end

  assign emptySlots = bundleValid ? (CNT_W'(SLOTS) - usedCnt) : '0;
endmodule

// File: rtl/bundle_packer.sv
module bundle_packer
  import bpk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [OP_W-1:0]        inOp,
  input  logic [REG_W-1:0]       inDst,
  input  logic [REG_W-1:0]       inSrcA,
  input  logic [REG_W-1:0]       inSrcB,
  input  logic                   bundleReady,
  output logic                   bundleValid,
  output logic [SLOTS-1:0]       slotValid,
  output logic [SLOTS*IDX_W-1:0] slotIdx,
  output logic [SLOTS*OP_W-1:0]  slotOp,
  output logic [CNT_W-1:0]       emptySlots
);
  strobe_t          stb;
  instr_t           inInstr;
  instr_t           ent [DEPTH];
  logic [DEPTH-1:0] winValid;
  logic [IDX_W-1:0] idxArr [SLOTS];
  logic [OP_W-1:0]  opArr [SLOTS];

  assign inInstr = '{op: inOp, dst: inDst, srcA: inSrcA, srcB: inSrcB};

  bp_window u_win (
    .clk(clk), .rst(rst), .stb(stb), .inInstr(inInstr),
    .ent(ent), .entValid(winValid)
  );

  bp_ctrl u_ctrl (
    .ent(ent), .entValid(winValid), .inValid(inValid), .bundleReady(bundleReady),
    .stb(stb), .inReady(inReady), .bundleValid(bundleValid),
    .slotValid(slotValid), .slotIdx(idxArr), .slotOp(opArr), .emptySlots(emptySlots)
  );

  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_flat
    assign slotIdx[gs*IDX_W +: IDX_W] = idxArr[gs];
    assign slotOp[gs*OP_W +: OP_W]    = opArr[gs];
  end
endmodule

// File: rtl/bundle_packer_chk.sv
module bundle_packer_chk
  import bpk_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bundleReady,
  input logic             bundleValid,
  input logic             inReady,
  input logic [SLOTS-1:0] slotValid,
  input logic [CNT_W-1:0] emptySlots,
  input logic [DEPTH-1:0] winValid,
  input logic [DEPTH-1:0] retire
);
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    !bundleReady |-> (!bundleValid && retire == '0));

  a_r8_empty_idle: assert property (@(posedge clk) disable iff (rst)
    !winValid[0] |-> !bundleValid);

  a_r6_slot_limit: assert property (@(posedge clk) disable iff (rst)
    ($countones(retire) <= SLOTS) && ($countones(retire) == $countones(slotValid)));

  a_r6_oldest_goes: assert property (@(posedge clk) disable iff (rst)
    bundleValid |-> (retire[0] && slotValid[0]));

  a_r7_slot_sum: assert property (@(posedge clk) disable iff (rst)
    bundleValid |-> (32'(emptySlots) + $countones(slotValid) == SLOTS));

  a_r10_packed_window: assert property (@(posedge clk) disable iff (rst)
    ((winValid >> 1) & ~winValid) == '0);

  a_r2_full_stall: assert property (@(posedge clk) disable iff (rst)
    ($countones(winValid) == DEPTH) |-> !inReady);

  a_r1_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (winValid == '0));
endmodule

bind bundle_packer bundle_packer_chk u_chk (
  .clk(clk), .rst(rst), .bundleReady(bundleReady), .bundleValid(bundleValid),
  .inReady(inReady), .slotValid(slotValid), .emptySlots(emptySlots),
  .winValid(winValid), .retire(stb.retire)
);

// File: tb/sim_bundle_packer.sv
`timescale 1ns/1ps
module sim_bundle_packer;
  localparam int D = 8, S = 5, IW = 3, OW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 0, bundleReady = 0;
  logic [3:0] inOp = 0, inDst = 0, inSrcA = 0, inSrcB = 0;
  logic inReady, bundleValid;
  logic [S-1:0] slotValid;
  logic [S*IW-1:0] slotIdx;
  logic [S*OW-1:0] slotOp;
  logic [2:0] emptySlots;

  bundle_packer u0 (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // bench window model
  int mCnt = 0;
  int mOp[D], mDst[D], mA[D], mB[D];
  bit mSel[D];
  int eN, eIdx[S];
  bit eValid, eReady;
  int lastN, lastIdx[S];

  task automatic chk(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit hazard(int i, int j);
    return (mDst[j] == mA[i]) || (mDst[j] == mB[i]) || (mDst[i] == mDst[j]) ||
           (mDst[i] == mA[j]) || (mDst[i] == mB[j]);
  endfunction

  task automatic predict(bit br);
    eN = 0;
    eReady = (mCnt < D);
    eValid = br && (mCnt > 0);
    for (int s = 0; s < S; s++) eIdx[s] = 0;
    for (int i = 0; i < D; i++) mSel[i] = 0;
    if (eValid) begin
      for (int i = 0; i < mCnt; i++) begin
        bit ok = 1;
        for (int j = 0; j < i; j++) if (hazard(i, j)) ok = 0;
        if (ok && eN < S) begin
          mSel[i] = 1; eIdx[eN] = i; eN++;
        end
      end
    end
  endtask

  task automatic step(bit v, int op, int d, int a, int b, bit br);
    int k;
    int tOp[D], tDst[D], tA[D], tB[D];
    @(negedge clk);
    inValid = v; inOp = 4'(op); inDst = 4'(d); inSrcA = 4'(a); inSrcB = 4'(b);
    bundleReady = br;
    #1;
    predict(br);
    chk("R2 inReady", int'(inReady), int'(eReady));
    chk("R8 bundleValid", int'(bundleValid), int'(eValid));
    chk("R7 emptySlots", int'(emptySlots), eValid ? S - eN : 0);
    lastN = 0;
    for (int s = 0; s < S; s++) begin
      chk("R6 slotValid", int'(slotValid[s]), int'(s < eN));
      if (s < eN) begin
        chk("R6 slotIdx", int'(slotIdx[s*IW +: IW]), eIdx[s]);
        chk("R6 slotOp", int'(slotOp[s*OW +: OW]), mOp[eIdx[s]]);
      end
      lastIdx[s] = int'(slotIdx[s*IW +: IW]);
      if (slotValid[s]) lastN++;
    end
    @(posedge clk);
    k = 0;
    for (int i = 0; i < mCnt; i++) if (!mSel[i]) begin
      tOp[k] = mOp[i]; tDst[k] = mDst[i]; tA[k] = mA[i]; tB[k] = mB[i]; k++;
    end
    if (v && eReady) begin
      tOp[k] = op; tDst[k] = d; tA[k] = a; tB[k] = b; k++;
    end
    for (int i = 0; i < k; i++) begin
      mOp[i] = tOp[i]; mDst[i] = tDst[i]; mA[i] = tA[i]; mB[i] = tB[i];
    end
    mCnt = k;
  endtask

  task automatic load(int op, int d, int a, int b);
    step(1, op, d, a, b, 0);
  endtask

  task automatic drain(string tag, int n, int i0, int i1);
    step(0, 0, 0, 0, 0, 1);
    chk({tag, " count"}, lastN, n);
    if (n > 0) chk({tag, " idx0"}, lastIdx[0], i0);
    if (n > 1) chk({tag, " idx1"}, lastIdx[1], i1);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; inValid = 0; bundleReady = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    mCnt = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R1 reset state
    #1;
    chk("R1 bundleValid", int'(bundleValid), 0);
    chk("R1 inReady", int'(inReady), 1);

    // R9 sum tree plus unrelated instruction
    load(1, 2, 0, 1);   load(1, 5, 3, 4);  load(1, 8, 6, 7);   load(1, 11, 9, 10);
    load(1, 12, 2, 5);  load(1, 13, 8, 11); load(1, 14, 12, 13); load(2, 15, 0, 1);
    step(1, 3, 1, 1, 1, 0);   // R2 window full: offer refused
    chk("R2 full refuses", mCnt, 8);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 bundle1 count", lastN, 5);
    chk("R9 bundle1 slot4", lastIdx[4], 7);
    chk("R9 bundle1 slot3", lastIdx[3], 3);
    drain("R9 bundle2", 2, 0, 1);
    drain("R9 bundle3", 1, 0, 0);
    drain("R8 empty window", 0, 0, 0);

    // R3 read-after-write: dependent issues next bundle
    load(1, 1, 2, 3); load(1, 4, 1, 1);
    drain("R3 producer", 1, 0, 0);
    drain("R3 consumer", 1, 0, 0);

    // R4 write-after-read and write-after-write
    load(1, 2, 1, 1); load(1, 1, 3, 3); load(1, 1, 5, 5);
    drain("R4 first", 1, 0, 0);
    drain("R4 second", 1, 0, 0);
    drain("R4 third", 1, 0, 0);

    // R5 bypass of blocked entry, R10 compaction of survivor
    load(1, 6, 7, 7); load(1, 8, 6, 6); load(1, 9, 10, 10); load(1, 11, 8, 8);
    drain("R5 bypass", 2, 0, 2);
    drain("R10 shifted", 1, 0, 0);
    drain("R10 last", 1, 0, 0);

    // R6 oldest-first with seven independent entries
    for (int i = 0; i < 7; i++) load(i, i, 8 + i, 8 + i);
    drain("R6 full bundle", 5, 0, 1);
    chk("R7 full bundle empty", int'(emptySlots), 0);
    drain("R6 remainder", 2, 0, 1);

    // random traffic, small register set to create hazards
    for (int c = 0; c < 3000; c++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 5),
           $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 4) != 0);

    // R1 reset mid-traffic
    doReset();
    #1;
    chk("R1 reset clears", int'(bundleValid) + 2 * int'(!inReady), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule